// File: doc/BRIEF.md
# Stack-Addressed Register File with Tags

This block holds eight wide data registers that software addresses relative to a rotating top-of-stack pointer. Stack slot i maps to physical register (TOP + i) mod 8. Every physical register carries a 2-bit tag: 00 means valid and 11 means empty. Pushing moves the pointer down and writes the new top. Popping marks the old top empty and moves the pointer up. No data is shifted in either case. The block also supports exchange with the top slot, and reads and writes to any slot relative to the top.

The same storage has a second view that addresses the registers by physical number. This packed-integer view reads and writes the low 64 bits of a register. Any access through it marks every register valid. A bulk command marks every register empty and leaves the data in place. A push onto an occupied slot raises a one-cycle overflow flag. A read or pop of an empty slot raises a one-cycle underflow flag. In both cases the stack is left unchanged.

Each operation is presented on `op_i` for one clock. Its results appear on `rdata_o`, `pk_rdata_o`, `top_o` and the two flags after that rising edge.

Top module: `stk_rf`

## Requirements
- R1: After reset, or after INIT (op 1), the pointer is 0, every tag is empty (11) and both flags are clear. Reset also clears `rdata_o` and `pk_rdata_o`.
- R2: PUSH (op 2) decrements the pointer and writes `wdata_i` into the new slot 0, so the old ST(i) becomes ST(i+1).
- R3: PUSH onto a target whose tag is not empty sets `ovf_o` for one cycle. The pointer and the contents are left unchanged.
- R4: STORE (op 3) puts ST0 on `rdata_o` and leaves the pointer and the tags unchanged.
- R5: STORE_POP (op 4) puts ST0 on `rdata_o`, marks it empty and increments the pointer. If ST0 is empty, it sets `unf_o` and changes nothing.
- R6: XCHG (op 5) swaps ST0 with ST(`idx_i`). If either slot is empty, it sets `unf_o` and swaps nothing.
- R7: READ (op 6) puts ST(`idx_i`) on `rdata_o`, or sets `unf_o` if that slot is empty. WRITE (op 7) stores `wdata_i` into ST(`idx_i`) and marks it valid.
- R8: EMPTY_ALL (op 8) sets every tag to 11 and keeps the pointer and the register data.
- R9: PK_WRITE (op 10) writes `pk_wdata_i` into bits 63:0 of physical register `idx_i` and all ones into bits 79:64. It marks every tag valid (00).
- R10: PK_READ (op 9) puts bits 63:0 of physical register `idx_i` on `pk_rdata_o` and marks every tag valid.
- R11: The flags reflect only the operation of the previous cycle, and `ovf_o` and `unf_o` are never set together. On underflow, `rdata_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (0 = no operation) |
| idx_i | input | 3 | Stack offset, or physical register number for packed ops |
| wdata_i | input | 80 | Data for PUSH and WRITE |
| pk_wdata_i | input | 64 | Data for PK_WRITE |
| rdata_o | output | 80 | Result of STORE, STORE_POP and READ |
| pk_rdata_o | output | 64 | Result of PK_READ |
| top_o | output | 3 | Current top-of-stack pointer |
| ovf_o | output | 1 | Stack overflow, one cycle |
| unf_o | output | 1 | Stack underflow, one cycle |

## Verification
The bench fills all eight slots and then pushes a ninth value. A design that checked the wrong slot for overflow would either wrap silently over the oldest entry or refuse the eighth push. Exchanges and reads at offsets that wrap past physical register 7 catch a pointer sum done without modulo. A read after the bulk empty and a second packed read must return the original data, which exposes a design that clears data along with the tags. A packed write followed by a relative read checks the all-ones upper field and the tag validation, and a later push must then overflow.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int NREG  = 8;
    localparam int DW    = 80;
    localparam int PKW   = 64;
    localparam int PTR_W = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_INIT  = 4'd1,
        OP_PUSH  = 4'd2,
        OP_STORE = 4'd3,
        OP_POP   = 4'd4,
        OP_XCHG  = 4'd5,
        OP_RD    = 4'd6,
        OP_WR    = 4'd7,
        OP_EMPTY = 4'd8,
        OP_PKRD  = 4'd9,
        OP_PKWR  = 4'd10
    } op_e;

    localparam logic [1:0] TAG_VALID = 2'b00;
    localparam logic [1:0] TAG_EMPTY = 2'b11;
endpackage

// File: rtl/stk_phys_map.sv
module stk_phys_map #(
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0] top_i,
    input  logic [PTR_W-1:0] off_i,
    output logic [PTR_W-1:0] phys_o
);
    // modulo wrap comes from the truncated sum
    assign phys_o = top_i + off_i;
endmodule

// File: rtl/stk_rf.sv
module stk_rf
    import stk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op_i,
    input  logic [PTR_W-1:0]   idx_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [PKW-1:0]     pk_wdata_i,
    output logic [DW-1:0]      rdata_o,
    output logic [PKW-1:0]     pk_rdata_o,
    output logic [PTR_W-1:0]   top_o,
    output logic               ovf_o,
    output logic               unf_o
);
    localparam int HIW = DW - PKW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [NREG-1:0][1:0]    tags;
        logic [PTR_W-1:0]        top;
        logic [DW-1:0]           rdata;
        logic [PKW-1:0]          pkrd;
        logic                    ovf;
        logic                    unf;
    } state_t;

    state_t st_q, st_d;
    logic [PTR_W-1:0] push_phys, rel_phys;
    op_e op;

    assign op = op_e'(op_i);

    // new top for a push: TOP + (NREG-1), i.e. TOP - 1
    stk_phys_map #(.PTR_W(PTR_W)) u_push_map (
        .top_i  (st_q.top),
        .off_i  ({PTR_W{1'b1}}),
        .phys_o (push_phys)
    );

    // slot addressed by idx_i relative to the top
    stk_phys_map #(.PTR_W(PTR_W)) u_rel_map (
        .top_i  (st_q.top),
        .off_i  (idx_i),
        .phys_o (rel_phys)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        unique case (op)
            OP_INIT: begin
                st_d.top = '0;
                for (int k = 0; k < NREG; k++) st_d.tags[k] = TAG_EMPTY;
            end
            OP_PUSH: begin
                if (st_q.tags[push_phys] != TAG_EMPTY) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.top             = push_phys;
                    st_d.regs[push_phys] = wdata_i;
                    st_d.tags[push_phys] = TAG_VALID;
                end
            end
            OP_STORE, OP_POP: begin
                if (st_q.tags[st_q.top] == TAG_EMPTY) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.rdata = st_q.regs[st_q.top];
                    if (op == OP_POP) begin
                        st_d.tags[st_q.top] = TAG_EMPTY;
                        st_d.top            = st_q.top + PTR_W'(1);
                    end
                end
            end
            OP_XCHG: begin
                if (st_q.tags[st_q.top] == TAG_EMPTY || st_q.tags[rel_phys] == TAG_EMPTY) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.regs[st_q.top] = st_q.regs[rel_phys];
                    st_d.regs[rel_phys] = st_q.regs[st_q.top];
                end
            end
            OP_RD: begin
                if (st_q.tags[rel_phys] == TAG_EMPTY) st_d.unf = 1'b1;
                else                                  st_d.rdata = st_q.regs[rel_phys];
            end
            OP_WR: begin
                st_d.regs[rel_phys] = wdata_i;
                st_d.tags[rel_phys] = TAG_VALID;
            end
            OP_EMPTY: begin
                for (int k = 0; k < NREG; k++) st_d.tags[k] = TAG_EMPTY;
            end
            OP_PKRD: begin
                st_d.pkrd = st_q.regs[idx_i][PKW-1:0];
                for (int k = 0; k < NREG; k++) st_d.tags[k] = TAG_VALID;
            end
            OP_PKWR: begin
                st_d.regs[idx_i] = {{HIW{1'b1}}, pk_wdata_i};
                for (int k = 0; k < NREG; k++) st_d.tags[k] = TAG_VALID;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.tags  <= {NREG{TAG_EMPTY}};
        end else begin
            st_q       <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign pk_rdata_o = st_q.pkrd;
    assign top_o      = st_q.top;
    assign ovf_o      = st_q.ovf;
    assign unf_o      = st_q.unf;
endmodule

// File: rtl/stk_rf_chk.sv
module stk_rf_chk
    import stk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [PTR_W-1:0] top_o,
    input logic             ovf_o,
    input logic             unf_o
);
    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH && !ovf_o) |=>
            (ovf_o ? (top_o == $past(top_o)) : (top_o == $past(top_o) - PTR_W'(1))));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(op_i) == OP_PUSH && top_o == $past(top_o)));

    p_store_keeps_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_STORE |=> $stable(top_o));

    p_pop_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=>
            (unf_o ? (top_o == $past(top_o)) : (top_o == $past(top_o) + PTR_W'(1))));

    p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_INIT |=> (top_o == '0 && !ovf_o && !unf_o));

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    p_unf_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> ($past(op_i) == OP_STORE || $past(op_i) == OP_POP ||
                   $past(op_i) == OP_XCHG  || $past(op_i) == OP_RD));
endmodule

bind stk_rf stk_rf_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .top_o (top_o),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
);

// File: tb/stk_rf_tb.sv
module stk_rf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [2:0]  idx = 3'd0;
    logic [79:0] wdata = '0;
    logic [63:0] pk_wdata = '0;
    logic [79:0] rdata;
    logic [63:0] pk_rdata;
    logic [2:0]  top;
    logic        ovf, unf;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_rf u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .idx_i(idx), .wdata_i(wdata),
        .pk_wdata_i(pk_wdata), .rdata_o(rdata), .pk_rdata_o(pk_rdata),
        .top_o(top), .ovf_o(ovf), .unf_o(unf)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  idx;
        logic [15:0] d;
        logic [2:0]  etop;
        logic        eovf;
        logic        eunf;
        logic        chk;
        logic [15:0] erd;
    } vec_t;

    localparam int NV = 29;
    // op: 2 push, 3 store, 4 store_pop, 5 xchg, 6 read, 7 write, 8 empty-all
    localparam vec_t VEC [NV] = '{
        '{4'd3, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R5/R4 empty store
        '{4'd2, 3'd0, 16'h1111, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        '{4'd2, 3'd0, 16'h2222, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        '{4'd2, 3'd0, 16'h3333, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2
        '{4'd6, 3'd2, 16'h0000, 3'd5, 1'b0, 1'b0, 1'b1, 16'h1111}, // R7 read ST2
        '{4'd5, 3'd2, 16'h0000, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0000}, // R6 xchg
        '{4'd3, 3'd0, 16'h0000, 3'd5, 1'b0, 1'b0, 1'b1, 16'h1111}, // R4/R6
        '{4'd6, 3'd2, 16'h0000, 3'd5, 1'b0, 1'b0, 1'b1, 16'h3333}, // R6
        '{4'd6, 3'd4, 16'h0000, 3'd5, 1'b0, 1'b1, 1'b1, 16'h3333}, // R7/R11 empty read
        '{4'd7, 3'd1, 16'h4444, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0000}, // R7 write
        '{4'd6, 3'd1, 16'h0000, 3'd5, 1'b0, 1'b0, 1'b1, 16'h4444}, // R7
        '{4'd4, 3'd0, 16'h0000, 3'd6, 1'b0, 1'b0, 1'b1, 16'h1111}, // R5
        '{4'd4, 3'd0, 16'h0000, 3'd7, 1'b0, 1'b0, 1'b1, 16'h4444}, // R5
        '{4'd4, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1, 16'h3333}, // R5
        '{4'd4, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b1, 16'h3333}, // R5 underflow
        '{4'd5, 3'd1, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R6 empty xchg
        '{4'd2, 3'd0, 16'hA000, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 fill
        '{4'd2, 3'd0, 16'hA001, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA002, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA003, 3'd4, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA004, 3'd3, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA005, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA006, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hA007, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000},
        '{4'd2, 3'd0, 16'hBBBB, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0000}, // R3 overflow
        '{4'd3, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1, 16'hA007}, // R3 unchanged
        '{4'd6, 3'd7, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b1, 16'hA000}, // R7 wrap
        '{4'd8, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R8
        '{4'd3, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0000}  // R8 now empty
    };

    task automatic check(input string req, input logic [79:0] got, input logic [79:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at negedge, result registered on next posedge, sampled at following negedge
    task automatic do_op(input logic [3:0] o, input logic [2:0] i,
                         input logic [79:0] wd, input logic [63:0] pwd);
        op = o; idx = i; wdata = wd; pk_wdata = pwd;
        @(negedge clk);
        op = 4'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset top", {77'd0, top}, 80'd0);
        check("R1 reset flags", {78'd0, ovf, unf}, 80'd0);
        check("R1 reset rdata", rdata, 80'd0);
        check("R1 reset pk_rdata", {16'd0, pk_rdata}, 80'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            do_op(VEC[v].op, VEC[v].idx, {5{VEC[v].d}}, 64'd0);
            check($sformatf("R2..R8 vec%0d top", v), {77'd0, top}, {77'd0, VEC[v].etop});
            check($sformatf("R3/R11 vec%0d ovf", v), {79'd0, ovf}, {79'd0, VEC[v].eovf});
            check($sformatf("R5/R11 vec%0d unf", v), {79'd0, unf}, {79'd0, VEC[v].eunf});
            if (VEC[v].chk)
                check($sformatf("R4/R7 vec%0d rdata", v), rdata, {5{VEC[v].erd}});
        end

        // R10: packed read of physical 0 (holds A007), data kept through empty-all (R8)
        do_op(4'd9, 3'd0, '0, '0);
        check("R10 pk read", {16'd0, pk_rdata}, {16'd0, {4{16'hA007}}});
        do_op(4'd3, 3'd0, '0, '0);
        check("R8/R10 tags valid after pk read", {79'd0, unf}, 80'd0);
        check("R8 data kept", rdata, {5{16'hA007}});

        // R9: packed write to physical 3, read back as ST3 (top is 0)
        do_op(4'd8, 3'd0, '0, '0);
        do_op(4'd10, 3'd3, '0, 64'h0123_4567_89AB_CDEF);
        do_op(4'd6, 3'd3, '0, '0);
        check("R9 pk write upper ones", rdata, 80'hFFFF_0123_4567_89AB_CDEF);
        check("R9 tags valid", {79'd0, unf}, 80'd0);
        do_op(4'd2, 3'd0, {5{16'hCCCC}}, '0);
        check("R3/R9 push overflow after pk", {78'd0, ovf, unf}, 80'd2);
        check("R3 top unchanged", {77'd0, top}, 80'd0);
        do_op(4'd0, 3'd0, '0, '0);
        check("R11 flags clear after nop", {78'd0, ovf, unf}, 80'd0);

        // R1: init empties everything
        do_op(4'd4, 3'd0, '0, '0);
        do_op(4'd1, 3'd0, '0, '0);
        check("R1 init top", {77'd0, top}, 80'd0);
        do_op(4'd6, 3'd5, '0, '0);
        check("R1 init empties", {79'd0, unf}, 80'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule